// File: doc/BRIEF.md
# Block Memory Transfer and Search Sequencer

This block executes the block-move and block-search operations of an 8-bit processor that keeps 16-bit register pairs. A start pulse hands it a 3-bit operation code, the accumulator, a source pointer (HL), a destination pointer (DE), a byte counter (BC) and the current flag byte. The block then drives a single-port byte memory on its own. It returns the updated pointers, the updated count and the updated flags, and it marks the end with a one-clock done pulse.

Each step has two cycles. The first cycle reads the byte at the source pointer. The second cycle does one of two things. In a copy, it writes that byte to the destination pointer. In a search, it compares the byte with the accumulator and does not access memory. In both cases the second cycle also moves the pointers and decrements the counter. A single-step operation does one step. A repeating operation keeps going by itself until the counter is used up, and a repeating search also stops at its first match. The memory must return read data combinationally, in the same cycle as the address.

Top module: `blkmem_seq`

## Requirements
- R1: While reset is held and after it is released, done and mem_we are 0, and hl_out, de_out, bc_out and flags_out are all 0.
- R2: Operation code bits: bit 0 selects search (1) or copy (0), bit 1 selects decrementing (1) or incrementing (0) pointers, and bit 2 selects repeat (1) or single step (0). The block samples start only when it is idle, so a start pulse during an operation has no effect on that operation.
- R3: A step begins with a read cycle that drives mem_addr = current source pointer and mem_we = 0. In a copy, the next cycle drives mem_addr = destination pointer, mem_wdata = the byte just read and mem_we = 1, for that one cycle only. In a search, the next cycle keeps mem_we = 0.
- R4: Every step moves the source pointer by one and decrements the count modulo 2^16. A copy also moves the destination pointer by one, while a search leaves it unchanged. Pointers wrap modulo 2^16.
- R5: A copy step clears flag bits H (bit 4), N (bit 1) and P/V (bit 2), then sets P/V if the decremented count is nonzero. S (bit 7) and Z (bit 6) keep their values.
- R6: A search step sets N, clears H, sets S to bit 7 of (A − byte), sets Z when A equals the byte, and sets P/V when A equals the byte or when the decremented count is nonzero.
- R7: Carry (bit 0) and bits 5 and 3 of the flag byte pass through every operation unchanged.
- R8: A repeating copy keeps taking steps until the count reaches zero.
- R9: A repeating search stops after the first step in which A equals the byte, or when the count reaches zero, whichever comes first.
- R10: A start count of zero runs over 65536 bytes: the first decrement gives 0xFFFF and sets P/V.
- R11: done is high for exactly one clock, in the cycle after the final step. The result outputs hold their values from that cycle until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| mode | input | 3 | Operation code: {repeat, down, search} |
| acc | input | 8 | Accumulator value to compare against |
| hl_in | input | 16 | Initial source pointer |
| de_in | input | 16 | Initial destination pointer |
| bc_in | input | 16 | Initial byte count |
| flags_in | input | 8 | Initial flag byte |
| mem_addr | output | 16 | Memory address |
| mem_rdata | input | 8 | Memory read data, valid in the same cycle as the address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| hl_out | output | 16 | Updated source pointer |
| de_out | output | 16 | Updated destination pointer |
| bc_out | output | 16 | Updated byte count |
| flags_out | output | 8 | Updated flag byte |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench runs copies in both directions, as single steps and as repeats, and checks that bytes land at the destination and that the flags change only in H, N and P/V. A copy that starts near 0xFFFF shows that the pointers wrap. Searches are run in four cases: an immediate match, a mismatch, a match partway through a region, and a region with no match at all. These cases separate the two ways a repeat can end. Zero-count starts, one single-step and one repeating search whose match lies 300 bytes in, show that the count wraps instead of stopping at once. A start pulse with a different code, driven during a repeating copy, shows that the running operation is not disturbed.

// File: rtl/blkmem_pkg.sv
package blkmem_pkg;

   localparam int FLAG_W = 8;
   localparam int FB_S   = 7;
   localparam int FB_Z   = 6;
   localparam int FB_H   = 4;
   localparam int FB_PV  = 2;
   localparam int FB_N   = 1;
   localparam int FB_C   = 0;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_READ = 2'd1,
      ST_EXEC = 2'd2,
      ST_FIN  = 2'd3
   } seq_state_t;

   // bit 2 = repeat, bit 1 = down, bit 0 = search
   typedef struct packed {
      logic rpt;
      logic down;
      logic cmp;
   } blk_mode_t;

endpackage

// File: rtl/blkmem_ptr.sv
module blkmem_ptr #(
   parameter int AW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] load_val,
   input  logic          step,
   input  logic          down,
   output logic [AW-1:0] q
);
   localparam logic [AW-1:0] ONE = AW'(1);

   logic [AW-1:0] q_next;

   always_comb begin
      q_next = q;
      if (load)
         q_next = load_val;
      else if (step)
         q_next = down ? (q - ONE) : (q + ONE);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else        q <= q_next;
   end

   // R4: each step moves the pointer by exactly one in the selected direction
   assert_ptr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load) |=> (q == ($past(down) ? ($past(q) - ONE) : ($past(q) + ONE))));

endmodule

// File: rtl/blkmem_cnt.sv
module blkmem_cnt #(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   input  logic          dec,
   output logic [CW-1:0] q,
   output logic          more
);
   localparam logic [CW-1:0] ONE = CW'(1);

   always_ff @(posedge clk) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= load_val;
      else if (dec)  q <= q - ONE;
   end

   // remaining count after this decrement is nonzero (zero wraps to all ones)
   assign more = (q != ONE);

   // R4 / R10: decrement is modulo 2^CW
   assert_cnt_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (dec && !load) |=> (q == $past(q) - ONE));

endmodule

// File: rtl/blkmem_flags.sv
module blkmem_flags
   import blkmem_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic [FLAG_W-1:0] flags_cur,
   input  logic              is_cmp,
   input  logic [DW-1:0]     acc,
   input  logic [DW-1:0]     data,
   input  logic              more,
   output logic [FLAG_W-1:0] flags_nxt,
   output logic              match
);
   logic [DW-1:0] diff;

   assign diff  = acc - data;
   assign match = (diff == '0);

   always_comb begin
      flags_nxt         = flags_cur;
      flags_nxt[FB_H]   = 1'b0;
      if (is_cmp) begin
         flags_nxt[FB_N]  = 1'b1;
         flags_nxt[FB_S]  = diff[DW-1];
         flags_nxt[FB_Z]  = match;
         flags_nxt[FB_PV] = match | more;
      end else begin
         flags_nxt[FB_N]  = 1'b0;
         flags_nxt[FB_PV] = more;
      end
   end

endmodule

// File: rtl/blkmem_seq.sv
module blkmem_seq
   import blkmem_pkg::*;
#(
   parameter int AW = 16,
   parameter int DW = 8,
   parameter int CW = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [2:0]        mode,
   input  logic [DW-1:0]     acc,
   input  logic [AW-1:0]     hl_in,
   input  logic [AW-1:0]     de_in,
   input  logic [CW-1:0]     bc_in,
   input  logic [FLAG_W-1:0] flags_in,
   output logic [AW-1:0]     mem_addr,
   input  logic [DW-1:0]     mem_rdata,
   output logic [DW-1:0]     mem_wdata,
   output logic              mem_we,
   output logic [AW-1:0]     hl_out,
   output logic [AW-1:0]     de_out,
   output logic [CW-1:0]     bc_out,
   output logic [FLAG_W-1:0] flags_out,
   output logic              done
);
   localparam int NPTR   = 2;
   localparam int PI_SRC = 0;
   localparam int PI_DST = 1;

   if (AW < 2) begin : g_bad_aw
      $error("blkmem_seq: AW must be at least 2");
   end
   if (DW < 2) begin : g_bad_dw
      $error("blkmem_seq: DW must be at least 2");
   end
   if (CW < 2) begin : g_bad_cw
      $error("blkmem_seq: CW must be at least 2");
   end

   seq_state_t        st_q, st_d;
   blk_mode_t         mode_q;
   logic [DW-1:0]     acc_q, data_q;
   logic [FLAG_W-1:0] flags_q, flags_nxt;
   logic [CW-1:0]     cnt_q;
   logic [AW-1:0]     ptr_q    [NPTR];
   logic [AW-1:0]     ptr_init [NPTR];
   logic [NPTR-1:0]   ptr_step;
   logic              take, exec, cnt_more, match, keep_going;

   assign take = (st_q == ST_IDLE) && start;
   assign exec = (st_q == ST_EXEC);

   always_comb begin
      ptr_init[PI_SRC] = hl_in;
      ptr_init[PI_DST] = de_in;
      ptr_step[PI_SRC] = exec;
      ptr_step[PI_DST] = exec && !mode_q.cmp;
   end

   for (genvar g = 0; g < NPTR; g++) begin : g_ptr
      blkmem_ptr #(.AW(AW)) u_ptr (
         .clk      (clk),
         .rst_n    (rst_n),
         .load     (take),
         .load_val (ptr_init[g]),
         .step     (ptr_step[g]),
         .down     (mode_q.down),
         .q        (ptr_q[g])
      );
   end

   blkmem_cnt #(.CW(CW)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (take),
      .load_val (bc_in),
      .dec      (exec),
      .q        (cnt_q),
      .more     (cnt_more)
   );

   blkmem_flags #(.DW(DW)) u_flags (
      .flags_cur (flags_q),
      .is_cmp    (mode_q.cmp),
      .acc       (acc_q),
      .data      (data_q),
      .more      (cnt_more),
      .flags_nxt (flags_nxt),
      .match     (match)
   );

   assign keep_going = mode_q.rpt && cnt_more && !(mode_q.cmp && match);

   always_comb begin
      st_d = st_q;
      case (st_q)
         ST_IDLE: if (start) st_d = ST_READ;
         ST_READ: st_d = ST_EXEC;
         ST_EXEC: st_d = keep_going ? ST_READ : ST_FIN;
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         mode_q  <= '0;
         acc_q   <= '0;
         data_q  <= '0;
         flags_q <= '0;
      end else begin
         st_q <= st_d;
         if (take) begin
            mode_q  <= blk_mode_t'(mode);
            acc_q   <= acc;
            flags_q <= flags_in;
         end
         if (st_q == ST_READ) data_q <= mem_rdata;
         if (exec) flags_q <= flags_nxt;
      end
   end

   assign mem_we    = exec && !mode_q.cmp;
   assign mem_addr  = mem_we ? ptr_q[PI_DST] : ptr_q[PI_SRC];
   assign mem_wdata = data_q;
   assign hl_out    = ptr_q[PI_SRC];
   assign de_out    = ptr_q[PI_DST];
   assign bc_out    = cnt_q;
   assign flags_out = flags_q;
   assign done      = (st_q == ST_FIN);

   // R11: completion pulse lasts one clock
   assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R11: results hold after completion
   assert_results_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> ($stable(bc_out) && $stable(flags_out) && $stable(hl_out)));

   // R3: a write is always preceded by its read cycle and never repeats
   assert_write_after_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> ($past(st_q) == ST_READ));
   assert_single_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> !mem_we);

   // R2: operation code is frozen while busy
   assert_mode_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != ST_IDLE) |=> $stable(mode_q));

   // R7: carry never changes during an operation
   assert_carry_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q != ST_IDLE) && ($past(st_q) != ST_IDLE)) |-> (flags_q[FB_C] == $past(flags_q[FB_C])));

   // R9: a search match ends the operation
   assert_stop_on_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (exec && mode_q.cmp && match) |=> done);

endmodule

// File: tb/blkmem_seq_test.sv
module blkmem_seq_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [2:0]  mode = '0;
   logic [7:0]  acc = '0;
   logic [15:0] hl_in = '0, de_in = '0, bc_in = '0;
   logic [7:0]  flags_in = '0;
   logic [15:0] mem_addr;
   logic [7:0]  mem_rdata, mem_wdata;
   logic        mem_we;
   logic [15:0] hl_out, de_out, bc_out;
   logic [7:0]  flags_out;
   logic        done;

   int vectors = 0;
   int fails   = 0;

   logic [7:0] dmem [0:65535];
   logic [7:0] rmem [0:65535];

   always #10 clk = ~clk;

   blkmem_seq uut (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .acc(acc),
      .hl_in(hl_in), .de_in(de_in), .bc_in(bc_in), .flags_in(flags_in),
      .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_wdata(mem_wdata),
      .mem_we(mem_we), .hl_out(hl_out), .de_out(de_out), .bc_out(bc_out),
      .flags_out(flags_out), .done(done)
   );

   assign mem_rdata = dmem[mem_addr];
   always @(posedge clk) if (mem_we) dmem[mem_addr] <= mem_wdata;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic poke(input logic [15:0] a, input logic [7:0] v);
      dmem[a] = v;
      rmem[a] = v;
   endtask

   // called at a negedge; returns at a negedge one cycle after done
   task automatic run_op(input logic [2:0] md, input logic [7:0] a,
                         input logic [15:0] hl, input logic [15:0] de,
                         input logic [15:0] bc, input logic [7:0] f, input bit noisy);
      logic [15:0] h, d, c;
      logic [7:0]  fl, dat, diff;
      bit cmp, dn, rp, go;
      h = hl; d = de; c = bc; fl = f;
      cmp = md[0]; dn = md[1]; rp = md[2];
      start = 1'b1; mode = md; acc = a;
      hl_in = hl; de_in = de; bc_in = bc; flags_in = f;
      @(negedge clk);
      start = noisy; mode = ~md; hl_in = ~hl; bc_in = 16'h0001; acc = ~a;
      go = 1'b1;
      while (go) begin
         chk("R3 read addr", mem_addr, h);
         chk("R3 read we", mem_we, 0);
         chk("R11 done low", done, 0);
         dat = rmem[h];
         @(negedge clk);
         start = 1'b0;
         if (!cmp) begin
            chk("R3 write addr", mem_addr, d);
            chk("R3 write we", mem_we, 1);
            chk("R3 write data", mem_wdata, dat);
            rmem[d] = dat;
         end else begin
            chk("R3 search no write", mem_we, 0);
         end
         chk("R11 done low", done, 0);
         diff = a - dat;
         c = c - 16'd1;
         if (!cmp) begin
            fl = (fl & 8'b1110_1001) | ((c != 0) ? 8'h04 : 8'h00);
         end else begin
            fl = (fl & 8'b0010_1001) | 8'h02 | (diff[7] ? 8'h80 : 8'h00)
               | ((diff == 0) ? 8'h44 : 8'h00) | ((c != 0) ? 8'h04 : 8'h00);
         end
         h = dn ? h - 16'd1 : h + 16'd1;
         if (!cmp) d = dn ? d - 16'd1 : d + 16'd1;
         go = rp && (c != 0) && !(cmp && diff == 0);
         @(negedge clk);
      end
      chk("R11 done high", done, 1);
      chk("R4 hl_out", hl_out, h);
      chk("R4 de_out", de_out, d);
      chk("R4/R10 bc_out", bc_out, c);
      chk("R5/R6/R7 flags_out", flags_out, fl);
      @(negedge clk);
      chk("R11 done one cycle", done, 0);
      chk("R11 hl hold", hl_out, h);
      chk("R11 bc hold", bc_out, c);
      chk("R11 flags hold", flags_out, fl);
   endtask

   task automatic check_region(input string req, input logic [15:0] base, input int n);
      for (int i = 0; i < n; i++) begin
         logic [15:0] ad;
         ad = base + 16'(i);
         chk(req, dmem[ad], rmem[ad]);
      end
   endtask

   initial begin
      for (int i = 0; i < 65536; i++) poke(16'(i), 8'((i * 7 + 3) & 255));
      repeat (3) @(negedge clk);
      // R1: reset values
      chk("R1 done", done, 0);
      chk("R1 we", mem_we, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 hl_out", hl_out, 0);
      chk("R1 de_out", de_out, 0);
      chk("R1 bc_out", bc_out, 0);
      chk("R1 flags_out", flags_out, 0);
      chk("R1 done after release", done, 0);

      // R2 R5: single copy up, all flags set on entry
      run_op(3'b000, 8'h00, 16'h1000, 16'h2000, 16'd5, 8'hFF, 1'b0);
      check_region("R3 copy up data", 16'h2000, 2);
      // R5: single copy down, count runs out
      run_op(3'b010, 8'h00, 16'h1100, 16'h2100, 16'd1, 8'h00, 1'b0);
      check_region("R3 copy down data", 16'h20FF, 3);
      // R6: single search up, match
      poke(16'h3000, 8'h5A);
      run_op(3'b001, 8'h5A, 16'h3000, 16'h1234, 16'd4, 8'hFF, 1'b0);
      // R6: single search down, mismatch with negative difference
      poke(16'h3010, 8'h90);
      run_op(3'b011, 8'h10, 16'h3010, 16'h0000, 16'd4, 8'h00, 1'b0);
      // R8 R2: repeat copy up with a stray start during the run
      run_op(3'b100, 8'h00, 16'h1200, 16'h2200, 16'd6, 8'h29, 1'b1);
      check_region("R8 repeat copy up data", 16'h2200, 8);
      // R8: repeat copy down
      run_op(3'b110, 8'h00, 16'h1300, 16'h2300, 16'd4, 8'h81, 1'b0);
      check_region("R8 repeat copy down data", 16'h22FC, 8);
      // R4 R8: repeat copy up across address wrap
      run_op(3'b100, 8'h00, 16'hFFFE, 16'h5000, 16'd3, 8'h00, 1'b0);
      check_region("R4 wrap copy data", 16'h5000, 3);
      // R9: repeat search up, match at third byte
      for (int i = 0; i < 10; i++) poke(16'h3100 + 16'(i), 8'h11);
      poke(16'h3102, 8'hC3);
      run_op(3'b101, 8'hC3, 16'h3100, 16'h0000, 16'd10, 8'h00, 1'b0);
      // R9: repeat search down, no match, count exhausted
      for (int i = 0; i < 5; i++) poke(16'h3200 - 16'(i), 8'h22);
      run_op(3'b111, 8'h23, 16'h3200, 16'h0000, 16'd5, 8'h01, 1'b0);
      // R10: single search with zero count
      poke(16'h3300, 8'h00);
      run_op(3'b001, 8'h01, 16'h3300, 16'h0000, 16'd0, 8'h00, 1'b0);
      // R10 R9: repeat search with zero count, match 300 bytes in
      for (int i = 0; i < 300; i++) poke(16'h4000 + 16'(i), 8'h00);
      poke(16'h4000 + 16'd300, 8'h5A);
      run_op(3'b101, 8'h5A, 16'h4000, 16'h0000, 16'd0, 8'h08, 1'b0);
      chk("R10 count after wrap", bc_out, 16'd65235);

      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule